// File: doc/BRIEF.md
# Daisy-Chained DAC Serial Programmer

This block programs a string of six 12-bit serial DACs wired as one long shift register. The DACs share three lines: a bit clock, a serial data line and an active-low select/load line. A client supplies a 72-bit word that holds all six levels and raises a one-cycle request. The block captures the word and drops the select/load line. It then sends the word one bit at a time. Each step of every bit lasts a programmable number of system clocks. Finally it raises select/load, and that rising edge updates every DAC output at once.

After reset the block waits for a programmable power-up pause. It then sends a built-in default word on its own, and only after that does it serve client requests. A busy output tells the client when a request will be taken. Requests that arrive while busy are dropped without effect.

Top module: `dac_chain_prog`

## Requirements
- R1: A frame carries 72 bits. Channel k (1..6) sits in word bits [12k-1:12k-12], so channel 1 is least significant. The bits leave in the order bit 71 first, down to bit 0 last, which means channel 6 goes first and each channel goes MSB first. Exactly 72 clock rises occur per frame.
- R2: For every bit, the data line holds its value for WAIT_CYC clocks before the bit clock rises. The bit clock then stays high for WAIT_CYC clocks. It is low for 2*WAIT_CYC clocks between consecutive rises. The data line does not change at the rising or the falling clock edge.
- R3: The select/load line falls 2*WAIT_CYC clocks before the first bit clock rise. The bit clock is never high while select/load is high.
- R4: Select/load rises WAIT_CYC clocks after the last bit clock fall. This rise ends the frame.
- R5: While not busy, the bit clock is low, the data line is low and select/load is high.
- R6: Busy is high during reset, the power-up pause and every frame. After select/load rises, busy stays high for exactly WAIT_CYC clocks, counting the cycle of the rise, and then falls.
- R7: After reset is released, select/load falls PWRUP_CYC clocks later. The block then sends the default word, in which channel k holds (k*DEF_STEP) mod 4096. With the default DEF_STEP = 0x249, this gives 0x249, 0x492, 0x6DB, 0x924, 0xB6D, 0xDB6.
- R8: A request seen while busy is low is accepted. One clock later, busy is high and select/load is low.
- R9: A request seen while busy is high is ignored. This includes the last cycle before busy falls. Such a request starts no frame and does not alter the frame in progress.
- R10: The word is captured in the cycle the request is accepted. Changes on the word input after that do not affect the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to program a new word |
| word_i | input | 72 | Six 12-bit levels; channel 1 in the low bits |
| busy_o | output | 1 | High while pausing or programming |
| dac_sclk_o | output | 1 | Shared DAC bit clock |
| dac_sdata_o | output | 1 | Serial data into the first DAC of the chain |
| dac_load_n_o | output | 1 | Shared active-low select/load; its rise updates the outputs |

## Verification
Two events can fall in the same cycle: the end of the hold after select/load rises, and a new client request. The bench raises a request in exactly the last cycle that busy is high. It expects that request to be dropped: busy stays low and no further clock activity or frame appears. A second run holds the request into the next cycle and expects a back-to-back frame, checked bit for bit. Word capture is probed by changing the word input in the cycle right after acceptance.

// File: rtl/dacprog_pkg.sv
package dacprog_pkg;

    typedef enum logic [2:0] {
        PH_PWRUP,
        PH_IDLE,
        PH_SELECT,
        PH_DATA,
        PH_CLKHI,
        PH_CLKLO,
        PH_LATCH
    } phase_e;

    typedef struct packed {
        logic sclk;
        logic sdata;
        logic load_n;
    } dac_pins_t;

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dacprog_timer.sv
module dacprog_timer
    import dacprog_pkg::*;
#(
    parameter int WAIT_CYC  = 4,
    parameter int PWRUP_CYC = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    input  logic pwrup_i,
    output logic done_o
);
    localparam int LIMIT = max_int(WAIT_CYC, PWRUP_CYC);
    localparam int CW    = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] last;

    assign last   = pwrup_i ? CW'(PWRUP_CYC - 1) : CW'(WAIT_CYC - 1);
    assign done_o = run_i && (cnt == last);

    always_ff @(posedge clk) begin
        if (rst || !run_i || done_o)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/dacprog_shifter.sv
module dacprog_shifter #(
    parameter int WIDTH = 72
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [WIDTH-1:0] value_i,
    input  logic             shift_i,
    output logic             msb_o
);
    logic [WIDTH-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst)
            sr <= '0;
        else if (load_i)
            sr <= value_i;
        else if (shift_i)
            sr <= {sr[WIDTH-2:0], 1'b0};
    end

    assign msb_o = sr[WIDTH-1];
endmodule

// File: rtl/dacprog_fsm.sv
module dacprog_fsm
    import dacprog_pkg::*;
#(
    parameter int FRAME_W = 72
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start_i,
    input  logic      tmr_done_i,
    input  logic      msb_i,
    output logic      run_o,
    output logic      pwrup_o,
    output logic      load_o,
    output logic      load_def_o,
    output logic      shift_o,
    output logic      busy_o,
    output dac_pins_t pins_o
);
    localparam int BCW = $clog2(FRAME_W);

    phase_e         phase;
    logic [BCW-1:0] bit_cnt;
    logic           accept;
    logic           in_bit;

    assign accept     = (phase == PH_IDLE) && start_i;
    assign load_def_o = (phase == PH_PWRUP) && tmr_done_i;
    assign load_o     = accept || load_def_o;
    assign shift_o    = (phase == PH_CLKLO) && tmr_done_i;
    assign run_o      = (phase != PH_IDLE);
    assign pwrup_o    = (phase == PH_PWRUP);
    assign busy_o     = (phase != PH_IDLE);
    assign in_bit     = (phase == PH_DATA) || (phase == PH_CLKHI) || (phase == PH_CLKLO);

    always_comb begin
        pins_o.sclk   = (phase == PH_CLKHI);
        pins_o.sdata  = in_bit && msb_i;
        pins_o.load_n = !(in_bit || (phase == PH_SELECT));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_PWRUP;
            bit_cnt <= '0;
        end else begin
            case (phase)
                PH_PWRUP:  if (tmr_done_i) phase <= PH_SELECT;
                PH_IDLE:   if (start_i) phase <= PH_SELECT;
                PH_SELECT: if (tmr_done_i) begin
                    phase   <= PH_DATA;
                    bit_cnt <= '0;
                end
                PH_DATA:   if (tmr_done_i) phase <= PH_CLKHI;
                PH_CLKHI:  if (tmr_done_i) phase <= PH_CLKLO;
                PH_CLKLO:  if (tmr_done_i) begin
                    bit_cnt <= bit_cnt + 1'b1;
                    phase   <= (bit_cnt == BCW'(FRAME_W - 1)) ? PH_LATCH : PH_DATA;
                end
                PH_LATCH:  if (tmr_done_i) phase <= PH_IDLE;
                default:   phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dac_chain_prog.sv
module dac_chain_prog
    import dacprog_pkg::*;
#(
    parameter int          CH_COUNT  = 6,
    parameter int          CH_WIDTH  = 12,
    parameter int          WAIT_CYC  = 4,
    parameter int          PWRUP_CYC = 1024,
    parameter logic [11:0] DEF_STEP  = 12'h249
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         start_i,
    input  logic [CH_COUNT*CH_WIDTH-1:0] word_i,
    output logic                         busy_o,
    output logic                         dac_sclk_o,
    output logic                         dac_sdata_o,
    output logic                         dac_load_n_o
);
    localparam int FRAME_W = CH_COUNT * CH_WIDTH;

    logic [FRAME_W-1:0] def_word;
    logic [FRAME_W-1:0] load_val;
    logic               tmr_done, run, pwrup, load, load_def, shift, msb;
    dac_pins_t          pins;

    for (genvar g = 0; g < CH_COUNT; g++) begin : g_def
        localparam int LEVEL = (g + 1) * int'(DEF_STEP);
        assign def_word[g*CH_WIDTH +: CH_WIDTH] = CH_WIDTH'(LEVEL);
    end

    assign load_val = load_def ? def_word : word_i;

    dacprog_timer #(.WAIT_CYC(WAIT_CYC), .PWRUP_CYC(PWRUP_CYC)) u_timer (
        .clk(clk), .rst(rst), .run_i(run), .pwrup_i(pwrup), .done_o(tmr_done)
    );

    dacprog_shifter #(.WIDTH(FRAME_W)) u_shift (
        .clk(clk), .rst(rst), .load_i(load), .value_i(load_val),
        .shift_i(shift), .msb_o(msb)
    );

    dacprog_fsm #(.FRAME_W(FRAME_W)) u_fsm (
        .clk(clk), .rst(rst), .start_i(start_i), .tmr_done_i(tmr_done),
        .msb_i(msb), .run_o(run), .pwrup_o(pwrup), .load_o(load),
        .load_def_o(load_def), .shift_o(shift), .busy_o(busy_o), .pins_o(pins)
    );

    assign dac_sclk_o   = pins.sclk;
    assign dac_sdata_o  = pins.sdata;
    assign dac_load_n_o = pins.load_n;
endmodule

// File: rtl/dac_chain_prog_checker.sv
module dac_chain_prog_checker (
    input logic clk,
    input logic rst,
    input logic start_i,
    input logic busy_o,
    input logic dac_sclk_o,
    input logic dac_sdata_o,
    input logic dac_load_n_o
);
    p_idle_rest_r5: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (dac_load_n_o && !dac_sclk_o && !dac_sdata_o));

    p_sclk_selected_r3: assert property (@(posedge clk) disable iff (rst)
        dac_sclk_o |-> !dac_load_n_o);

    p_setup_stable_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(dac_sclk_o) |-> $stable(dac_sdata_o));

    p_hold_stable_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(dac_sclk_o) |-> $stable(dac_sdata_o));

    p_busy_at_latch_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(dac_load_n_o) |-> busy_o);

    p_accept_r8: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && start_i) |=> (busy_o && !dac_load_n_o));
endmodule

bind dac_chain_prog dac_chain_prog_checker u_chk (
    .clk(clk), .rst(rst), .start_i(start_i), .busy_o(busy_o),
    .dac_sclk_o(dac_sclk_o), .dac_sdata_o(dac_sdata_o), .dac_load_n_o(dac_load_n_o)
);

// File: tb/sim_dac_chain_prog.sv
module sim_dac_chain_prog;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 4;
    localparam int PW = 1024;
    localparam int FW = 72;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic [FW-1:0] word_i = '0;
    logic          busy_o, dac_sclk_o, dac_sdata_o, dac_load_n_o;

    int checks = 0;
    int errors = 0;
    int frame_cnt = 0;
    logic [FW-1:0] exp_word;

    always #(CLK_PERIOD/2) clk = ~clk;

    dac_chain_prog #(.WAIT_CYC(W), .PWRUP_CYC(PW)) u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .word_i(word_i),
        .busy_o(busy_o), .dac_sclk_o(dac_sclk_o), .dac_sdata_o(dac_sdata_o),
        .dac_load_n_o(dac_load_n_o)
    );

    task automatic chk(input bit ok, input string req, input logic [FW-1:0] act,
                       input logic [FW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Serial line monitor, sampled on the falling clock edge
    logic          p_sclk = 1'b0, p_load = 1'b1, p_sdata = 1'b0, rise_data = 1'b0;
    logic [FW-1:0] shreg = '0;
    int gap = 0, bits = 0, lat_cnt = 0;
    bit lat_on = 0;

    always @(negedge clk) begin
        if (!rst) begin
            gap++;
            if (p_load && !dac_load_n_o) begin
                gap = 0; bits = 0; shreg = '0;
            end
            if (!p_sclk && dac_sclk_o) begin
                chk(gap == 2*W, "R2/R3 gap before rise", FW'(gap), FW'(2*W));
                chk(dac_sdata_o == p_sdata, "R2 setup stable", FW'(dac_sdata_o), FW'(p_sdata));
                shreg = {shreg[FW-2:0], dac_sdata_o};
                rise_data = dac_sdata_o;
                bits++;
                gap = 0;
            end
            if (p_sclk && !dac_sclk_o) begin
                chk(gap == W, "R2 high time", FW'(gap), FW'(W));
                chk(dac_sdata_o == rise_data, "R2 hold stable", FW'(dac_sdata_o), FW'(rise_data));
                gap = 0;
            end
            if (!p_load && dac_load_n_o) begin
                chk(gap == W, "R4 latch delay", FW'(gap), FW'(W));
                chk(bits == FW, "R1 bit count", FW'(bits), FW'(FW));
                chk(shreg == exp_word, "R1 frame content", shreg, exp_word);
                frame_cnt++;
                lat_on = 1; lat_cnt = 1;
            end else if (lat_on) begin
                if (busy_o) lat_cnt++;
                else begin
                    chk(lat_cnt == W, "R6 busy hold", FW'(lat_cnt), FW'(W));
                    lat_on = 0;
                end
            end
            if (!busy_o)
                chk(dac_load_n_o && !dac_sclk_o && !dac_sdata_o, "R5 idle rest",
                    FW'({dac_load_n_o, dac_sclk_o, dac_sdata_o}), FW'(3'b100));
        end
        p_sclk = dac_sclk_o; p_load = dac_load_n_o; p_sdata = dac_sdata_o;
    end

    task automatic wait_idle();
        while (busy_o) @(negedge clk);
    endtask

    task automatic t_reset_powerup();
        logic [FW-1:0] dw;
        int n;
        for (int k = 1; k <= 6; k++) dw[(k-1)*12 +: 12] = 12'((k * 'h249) % 4096);
        exp_word = dw;
        repeat (3) @(negedge clk);
        chk(busy_o && dac_load_n_o && !dac_sclk_o, "R6 reset state busy/lines",
            FW'({busy_o, dac_load_n_o, dac_sclk_o}), FW'(3'b110));
        rst = 1'b0;
        n = 0;
        while (dac_load_n_o) begin
            @(negedge clk); n++;
            if (!dac_load_n_o) break;
            chk(busy_o, "R6 busy in pause", FW'(busy_o), FW'(1));
            if (n > PW + 10) break;
        end
        chk(n == PW, "R7 power-up pause", FW'(n), FW'(PW));
        wait_idle();
        chk(frame_cnt == 1, "R7 default frame sent", FW'(frame_cnt), FW'(1));
    endtask

    task automatic t_client_frame(input logic [FW-1:0] w);
        int f0 = frame_cnt;
        wait_idle();
        exp_word = w; word_i = w; start_i = 1'b1;
        @(negedge clk);
        chk(busy_o && !dac_load_n_o, "R8 accept latency",
            FW'({busy_o, dac_load_n_o}), FW'(2'b10));
        start_i = 1'b0;
        word_i = ~w;
        wait_idle();
        chk(frame_cnt == f0 + 1, "R10/R1 client frame", FW'(frame_cnt), FW'(f0 + 1));
    endtask

    task automatic t_ignore_busy();
        int f0;
        logic [FW-1:0] a = 72'h0F0_1E2_2D3_3C4_4B5_5A6;
        wait_idle();
        f0 = frame_cnt;
        exp_word = a; word_i = a; start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        repeat (100) @(negedge clk);
        word_i = ~a; start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        wait_idle();
        repeat (20) @(negedge clk);
        chk(frame_cnt == f0 + 1, "R9 mid-frame request ignored", FW'(frame_cnt), FW'(f0 + 1));
        chk(!busy_o, "R9 no extra frame", FW'(busy_o), FW'(0));
    endtask

    task automatic t_boundary(input bit hold_two);
        int f0;
        logic [FW-1:0] c = 72'h123_456_789_ABC_DEF_0F1;
        logic [FW-1:0] d = 72'hFED_CBA_987_654_321_0E0;
        wait_idle();
        f0 = frame_cnt;
        exp_word = c; word_i = c; start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        while (!dac_load_n_o) @(negedge clk);
        repeat (W - 1) @(negedge clk);
        chk(busy_o, "R6 busy in last latch cycle", FW'(busy_o), FW'(1));
        word_i = d; start_i = 1'b1;
        @(negedge clk);
        chk(!busy_o, "R9 request at busy end dropped", FW'(busy_o), FW'(0));
        if (!hold_two) begin
            start_i = 1'b0;
            repeat (20) @(negedge clk);
            chk(frame_cnt == f0 + 1 && !busy_o, "R9 no frame after boundary request",
                FW'(frame_cnt), FW'(f0 + 1));
        end else begin
            exp_word = d;
            @(negedge clk);
            start_i = 1'b0;
            chk(busy_o && !dac_load_n_o, "R8 back-to-back accept",
                FW'({busy_o, dac_load_n_o}), FW'(2'b10));
            wait_idle();
            chk(frame_cnt == f0 + 2, "R1 back-to-back frame", FW'(frame_cnt), FW'(f0 + 2));
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset_powerup();
        t_client_frame({FW{1'b1}});
        t_client_frame('0);
        t_client_frame({36{2'b10}});
        t_client_frame(72'h800_000_000_000_000_000);
        t_client_frame(72'h000_000_000_000_000_001);
        t_ignore_busy();
        t_boundary(1'b0);
        t_boundary(1'b1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule